// File: doc/BRIEF.md
# Status Register Write-Protect Controller

This block keeps the 8-bit status register of a serial memory device and decides, every cycle, whether a status-register write and a memory-array write are allowed. It sits behind the serial command decoder, which hands it one-cycle pulses for the decoded commands. These pulses cover write enable, write disable, status read, the end of a status write (with the data byte and the count of data bits latched) and the end of an array write. The block also sees the level of the active-low write-protect pin and the byte address of the current array write.

The register holds a volatile write-enable latch and four retained bits: a protect-enable bit and a three-bit block-protect code. The protect code fences off an upper fraction of the address space, whose size is set by the `ADDR_W` parameter. Raising protect-enable while the write-protect pin is low freezes the retained bits, and so does lowering the pin after protect-enable is already set. A soft reset drops only the latch, while the power-on reset clears everything.

Top module: `srwp_ctrl`

## Requirements
- R1: `status` reads bit 7 = protect-enable, bits 4..2 = block-protect code (bit 4 most significant), bit 1 = write-enable latch; bits 6, 5 and 0 always read 0.
- R2: A `cmd_wren` pulse sets the latch (visible on `status[1]` after the next clock edge); a `cmd_wrdi` pulse clears it.
- R3: A `cmd_rdsr` pulse leaves the latch and the rest of `status` unchanged.
- R4: A status write (`sr_wr_end` with `sr_wr_bits` = 8) is executed when `sr_wr_ok` is high. It loads protect-enable from data bit 7 and the block-protect code from data bits 4..2, ignores data bits 6, 5, 1 and 0, and clears the latch.
- R5: When protect-enable is 1 and `wp_n` is 0, `sr_wr_ok` is 0 and a status write changes nothing; this holds whichever of the two conditions came first.
- R6: A status write whose `sr_wr_bits` is not exactly 8 is dropped: `status`, including the latch, is unchanged.
- R7: With the latch clear, `sr_wr_ok` is 0 and a status write changes nothing.
- R8: An address is protected by code 000: none; 001: upper 1/32; 010: upper 1/16; 011: upper 1/8; 100: upper 1/4; 101: upper 1/2; 110 and 111: every address. The upper 1/2^k is the set of addresses whose top k bits are all ones.
- R9: `arr_wr_ok` is 1 exactly when the latch is set and `arr_addr` is not protected.
- R10: An `arr_wr_done` pulse clears the latch.
- R11: `rst` clears all of `status`; `soft_rst` clears only the latch and keeps protect-enable and the block-protect code, and commands in a soft-reset cycle have no effect.
- R12: When a clearing event (`cmd_wrdi`, an executed status write or `arr_wr_done`) coincides with `cmd_wren`, the latch ends clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| soft_rst | input | 1 | Synchronous soft reset, clears the latch only |
| wp_n | input | 1 | Write-protect pin level, active low |
| cmd_wren | input | 1 | Write-enable command pulse |
| cmd_wrdi | input | 1 | Write-disable command pulse |
| cmd_rdsr | input | 1 | Status-read command pulse |
| sr_wr_end | input | 1 | Pulse at chip-select rise after a status-write command |
| sr_wr_bits | input | CNT_W | Number of data bits latched before chip-select rose |
| sr_wr_data | input | 8 | Status-write data byte |
| arr_wr_done | input | 1 | Pulse at completion of an array write |
| arr_addr | input | ADDR_W | Byte address of the current array write |
| status | output | 8 | Status byte |
| sr_wr_ok | output | 1 | A status write would be accepted now |
| arr_wr_ok | output | 1 | An array write to `arr_addr` would be accepted now |

## Verification
The bench builds the block with `ADDR_W` = 19, the smaller density. There the region thresholds fall at 0x7C000, 0x78000, 0x70000, 0x60000 and 0x40000, so every block-protect code is probed one byte below and exactly at its boundary, as well as at the lowest and highest address. `CNT_W` = 4 lets the bench send bit counts of 7 and 9 on either side of the exact count. Both orders of entering hardware protection are driven, as are the coinciding set and clear pulses and a soft reset taken with retained bits set.

// File: rtl/srwp_pkg.sv
package srwp_pkg;

    localparam int STS_W       = 8;
    localparam int BP_W        = 3;
    localparam int MAX_FRAC    = 5;
    localparam int SR_DATA_BITS = 8;

    localparam int BIT_PEN = 7;
    localparam int BIT_BPH = 4;
    localparam int BIT_BPL = 2;
    localparam int BIT_WEL = 1;

    typedef enum logic [BP_W-1:0] {
        BPC_NONE = 3'd0,
        BPC_F32  = 3'd1,
        BPC_F16  = 3'd2,
        BPC_F8   = 3'd3,
        BPC_F4   = 3'd4,
        BPC_F2   = 3'd5,
        BPC_ALL6 = 3'd6,
        BPC_ALL7 = 3'd7
    } bp_code_e;

    typedef struct packed {
        logic     pen;
        bp_code_e bp;
    } keep_bits_t;

    function automatic keep_bits_t fields_from_byte(input logic [STS_W-1:0] b);
        keep_bits_t k;
        k.pen = b[BIT_PEN];
        k.bp  = bp_code_e'(b[BIT_BPH:BIT_BPL]);
        return k;
    endfunction

    function automatic logic [STS_W-1:0] pack_status(input keep_bits_t k, input logic wel);
        logic [STS_W-1:0] s;
        s                  = '0;
        s[BIT_PEN]         = k.pen;
        s[BIT_BPH:BIT_BPL] = k.bp;
        s[BIT_WEL]         = wel;
        return s;
    endfunction

endpackage

// File: rtl/srwp_wel.sv
module srwp_wel (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic wel_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wel_o <= 1'b0;
        end else if (clr_i) begin
            wel_o <= 1'b0;
        end else if (set_i) begin
            wel_o <= 1'b1;
        end
    end
endmodule

// File: rtl/srwp_keep.sv
module srwp_keep
    import srwp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  keep_bits_t data_i,
    output keep_bits_t bits_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bits_o <= '{pen: 1'b0, bp: BPC_NONE};
        end else if (load_i) begin
            bits_o <= data_i;
        end
    end
endmodule

// File: rtl/srwp_region.sv
module srwp_region
    import srwp_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  bp_code_e          bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              prot_o
);
    logic [MAX_FRAC:1] top_ones;

    for (genvar k = 1; k <= MAX_FRAC; k++) begin : g_frac
        assign top_ones[k] = &addr_i[ADDR_W-1 -: k];
    end

    always_comb begin
        unique case (bp_i)
            BPC_NONE: prot_o = 1'b0;
            BPC_F32:  prot_o = top_ones[5];
            BPC_F16:  prot_o = top_ones[4];
            BPC_F8:   prot_o = top_ones[3];
            BPC_F4:   prot_o = top_ones[2];
            BPC_F2:   prot_o = top_ones[1];
            default:  prot_o = 1'b1;
        endcase
    end

    logic unused_lo;
    assign unused_lo = &{1'b0, addr_i[ADDR_W-MAX_FRAC-1:0]};
endmodule

// File: rtl/srwp_ctrl.sv
module srwp_ctrl
    import srwp_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              wp_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_rdsr,
    input  logic              sr_wr_end,
    input  logic [CNT_W-1:0]  sr_wr_bits,
    input  logic [7:0]        sr_wr_data,
    input  logic              arr_wr_done,
    input  logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        status,
    output logic              sr_wr_ok,
    output logic              arr_wr_ok
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(SR_DATA_BITS);

    logic       wel;
    keep_bits_t keep;
    logic       hw_lock;
    logic       sr_exec;
    logic       wel_set;
    logic       wel_clr;
    logic       addr_prot;

    // combined hardware lock, independent of which condition came first
    assign hw_lock  = keep.pen & ~wp_n;
    assign sr_wr_ok = wel & ~hw_lock;
    assign sr_exec  = sr_wr_end & (sr_wr_bits == FULL_CNT) & sr_wr_ok & ~soft_rst;

    assign wel_set = cmd_wren & ~soft_rst;
    assign wel_clr = soft_rst | cmd_wrdi | sr_exec | arr_wr_done;

    srwp_wel u_wel (
        .clk   (clk),
        .rst   (rst),
        .set_i (wel_set),
        .clr_i (wel_clr),
        .wel_o (wel)
    );

    srwp_keep u_keep (
        .clk    (clk),
        .rst    (rst),
        .load_i (sr_exec),
        .data_i (fields_from_byte(sr_wr_data)),
        .bits_o (keep)
    );

    srwp_region #(.ADDR_W(ADDR_W)) u_region (
        .bp_i   (keep.bp),
        .addr_i (arr_addr),
        .prot_o (addr_prot)
    );

    assign arr_wr_ok = wel & ~addr_prot;
    assign status    = pack_status(keep, wel);

    logic unused_in;
    assign unused_in = &{1'b0, cmd_rdsr, sr_wr_data[6:5], sr_wr_data[1:0]};
endmodule

// File: rtl/srwp_ctrl_chk.sv
module srwp_ctrl_chk #(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              soft_rst,
    input logic              wp_n,
    input logic              cmd_wren,
    input logic              cmd_wrdi,
    input logic              cmd_rdsr,
    input logic              sr_wr_end,
    input logic [CNT_W-1:0]  sr_wr_bits,
    input logic [7:0]        sr_wr_data,
    input logic              arr_wr_done,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [7:0]        status,
    input logic              sr_wr_ok,
    input logic              arr_wr_ok
);
    logic quiet;
    assign quiet = !cmd_wren && !cmd_wrdi && !arr_wr_done && !soft_rst;

    p_reserved_r1: assert property (@(posedge clk) disable iff (rst)
        (status[6:5] == 2'b00 && status[0] == 1'b0));

    p_wren_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_wren && !cmd_wrdi && !arr_wr_done && !soft_rst && !sr_wr_end) |=> status[1]);

    p_wrdi_clears_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_wrdi |=> !status[1]);

    p_rdsr_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_rdsr && quiet && !sr_wr_end) |=> $stable(status));

    p_lock_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        (sr_wr_end && status[7] && !wp_n) |=> $stable(status[7:2]));

    p_lock_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (status[7] && !wp_n) |-> !sr_wr_ok);

    p_badcount_r6: assert property (@(posedge clk) disable iff (rst)
        (sr_wr_end && sr_wr_bits != CNT_W'(8) && quiet) |=> $stable(status));

    p_nowel_r7: assert property (@(posedge clk) disable iff (rst)
        (sr_wr_end && !status[1]) |=> $stable(status[7:2]));

    p_full_r8: assert property (@(posedge clk) disable iff (rst)
        (status[4:3] == 2'b11) |-> !arr_wr_ok);

    p_arr_needs_wel_r9: assert property (@(posedge clk) disable iff (rst)
        arr_wr_ok |-> status[1]);

    p_done_clears_r10: assert property (@(posedge clk) disable iff (rst)
        arr_wr_done |=> !status[1]);

    p_soft_keeps_r11: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!status[1] && status[7:2] == $past(status[7:2])));

    p_clear_wins_r12: assert property (@(posedge clk) disable iff (rst)
        (cmd_wren && cmd_wrdi) |=> !status[1]);
endmodule

bind srwp_ctrl srwp_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_srwp_chk (.*);

// File: tb/test_srwp_ctrl.sv
module test_srwp_ctrl;
    localparam int AW = 19;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          soft_rst = 1'b0;
    logic          wp_n = 1'b1;
    logic          cmd_wren = 1'b0;
    logic          cmd_wrdi = 1'b0;
    logic          cmd_rdsr = 1'b0;
    logic          sr_wr_end = 1'b0;
    logic [CW-1:0] sr_wr_bits = '0;
    logic [7:0]    sr_wr_data = '0;
    logic          arr_wr_done = 1'b0;
    logic [AW-1:0] arr_addr = '0;
    logic [7:0]    status;
    logic          sr_wr_ok;
    logic          arr_wr_ok;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference state
    int m_wel = 0;
    int m_pen = 0;
    int m_bp  = 0;

    always #10 clk = ~clk;

    srwp_ctrl #(.ADDR_W(AW), .CNT_W(CW)) i_srwp_ctrl (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .wp_n(wp_n),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_rdsr(cmd_rdsr),
        .sr_wr_end(sr_wr_end), .sr_wr_bits(sr_wr_bits), .sr_wr_data(sr_wr_data),
        .arr_wr_done(arr_wr_done), .arr_addr(arr_addr),
        .status(status), .sr_wr_ok(sr_wr_ok), .arr_wr_ok(arr_wr_ok)
    );

    function automatic int thr_of(int bp);
        int size = 1 << AW;
        if (bp == 0) return size;
        if (bp >= 6) return 0;
        return size - (size >> (6 - bp));
    endfunction

    function automatic int m_prot(int bp, int addr);
        return (addr >= thr_of(bp)) ? 1 : 0;
    endfunction

    function automatic int m_status();
        return (m_pen << 7) | (m_bp << 2) | (m_wel << 1);
    endfunction

    function automatic int m_srok();
        return (m_wel == 1 && !(m_pen == 1 && wp_n == 1'b0)) ? 1 : 0;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one clock: inputs already driven after a falling edge
    task automatic cyc(string tag);
        int exec;
        #1;
        chk(tag, "sr_wr_ok", int'(sr_wr_ok), m_srok());
        chk(tag, "arr_wr_ok", int'(arr_wr_ok),
            (m_wel == 1 && m_prot(m_bp, int'(arr_addr)) == 0) ? 1 : 0);
        @(posedge clk);
        if (rst) begin
            m_wel = 0; m_pen = 0; m_bp = 0;
        end else if (soft_rst) begin
            m_wel = 0;
        end else begin
            exec = (sr_wr_end && sr_wr_bits == 8 && m_srok() == 1) ? 1 : 0;
            if (cmd_wrdi || exec == 1 || arr_wr_done) m_wel = 0;
            else if (cmd_wren) m_wel = 1;
            if (exec == 1) begin
                m_pen = int'(sr_wr_data[7]);
                m_bp  = int'(sr_wr_data[4:2]);
            end
        end
        @(negedge clk);
        chk(tag, "status", int'(status), m_status());
        soft_rst = 0; cmd_wren = 0; cmd_wrdi = 0; cmd_rdsr = 0;
        sr_wr_end = 0; arr_wr_done = 0;
    endtask

    task automatic wren(string tag);
        cmd_wren = 1; cyc(tag);
    endtask

    task automatic srwr(string tag, int bits, logic [7:0] d);
        sr_wr_end = 1; sr_wr_bits = CW'(bits); sr_wr_data = d; cyc(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst = 1; cyc("R11");
        rst = 0; cyc("R11");
        chk("R11", "status after reset", int'(status), 0);

        // R9: no latch, no array write
        arr_addr = '0; cyc("R9");
        // R2 / R3
        wren("R2");
        chk("R2", "latch set", int'(status[1]), 1);
        cmd_rdsr = 1; cyc("R3");
        chk("R3", "latch kept after read", int'(status[1]), 1);
        cmd_wrdi = 1; cyc("R2");
        chk("R2", "latch cleared", int'(status[1]), 0);

        // R7: status write without latch
        srwr("R7", 8, 8'h9C);
        chk("R7", "status unchanged", int'(status), 0);

        // R6: wrong bit counts
        wren("R6");
        srwr("R6", 7, 8'h9C);
        chk("R6", "short write dropped", int'(status), 8'h02);
        srwr("R6", 9, 8'h9C);
        chk("R6", "long write dropped", int'(status), 8'h02);

        // R4 / R1: accepted write, reserved data bits ignored
        srwr("R4", 8, 8'hFF);
        chk("R1", "layout after 0xFF", int'(status), 8'h9C);

        // R5: lock entered by lowering wp_n after pen set
        wp_n = 0; wren("R5");
        chk("R5", "sr_wr_ok low under lock", int'(sr_wr_ok), 0);
        srwr("R5", 8, 8'h00);
        chk("R5", "locked write rejected", int'(status), 8'h9E);
        wp_n = 1; cyc("R5");
        srwr("R4", 8, 8'h00);
        chk("R4", "unlocked write accepted", int'(status), 8'h00);

        // R5: other order, wp_n low first, then pen set
        wp_n = 0; wren("R5");
        srwr("R5", 8, 8'h80);
        chk("R5", "pen set while pin low", int'(status), 8'h80);
        wren("R5");
        srwr("R5", 8, 8'h00);
        chk("R5", "second write locked", int'(status), 8'h82);
        wp_n = 1;
        srwr("R4", 8, 8'h00);
        chk("R4", "write after pin high", int'(status), 8'h00);

        // R8 / R9: region sweep for every code
        for (int bp = 0; bp < 8; bp++) begin
            wren("R8");
            srwr("R8", 8, 8'(bp << 2));
            wren("R8");
            begin
                int t = thr_of(bp);
                int pts[4];
                pts[0] = 0; pts[1] = (t > 0) ? t - 1 : 0;
                pts[2] = (t < (1 << AW)) ? t : (1 << AW) - 1; pts[3] = (1 << AW) - 1;
                for (int i = 0; i < 4; i++) begin
                    arr_addr = AW'(pts[i]);
                    cyc("R8");
                    chk("R8", "region boundary", int'(arr_wr_ok),
                        m_prot(bp, pts[i]) == 1 ? 0 : 1);
                end
            end
            cmd_wrdi = 1; cyc("R9");
        end
        wren("R8");
        srwr("R8", 8, 8'h00);

        // R10
        wren("R10");
        arr_wr_done = 1; cyc("R10");
        chk("R10", "latch cleared by array write", int'(status[1]), 0);

        // R12
        cmd_wren = 1; cmd_wrdi = 1; cyc("R12");
        chk("R12", "clear beats set", int'(status[1]), 0);
        cmd_wren = 1; arr_wr_done = 1; cyc("R12");
        chk("R12", "done beats set", int'(status[1]), 0);

        // R11: soft reset keeps retained bits
        wren("R11");
        srwr("R11", 8, 8'h94);
        wren("R11");
        soft_rst = 1; cmd_wren = 1; cyc("R11");
        chk("R11", "soft reset", int'(status), 8'h94);
        rst = 1; cyc("R11");
        rst = 0; cyc("R11");
        chk("R11", "power-on reset", int'(status), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule